// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous host and an external asynchronous static RAM of 512K bytes. The host presents one transfer at a time through a valid/ready port. Each transfer carries a 19-bit address, a write flag and a write byte. The controller turns each transfer into a registered sequence of active-low chip select, write enable and output enable. It drives the address lines and controls a split 8-bit data bus: an output byte, an input byte and a tristate enable that the pad ring uses to build the bidirectional pins. Read bytes go back to the host with a one-cycle valid pulse.

The RAM's minimum times for access, write pulse and output release are given to the controller as whole-clock-cycle parameters. The nanosecond figures are rounded up. With a 10 ns clock the defaults are a 2-cycle read access, a 2-cycle write pulse and 1 turnaround cycle. A state machine counts these phases out. Its states are:
- `ST_IDLE`: standby, chip select high, ready asserted.
- `ST_RD_ACC`: read access with output enable low.
- `ST_RD_TURN`: bus release after a read, all strobes high.
- `ST_WR_SETUP`: address and data settle, write enable high.
- `ST_WR_PULSE`: write enable low.
- `ST_WR_END`: write enable high, data still driven.

Its transitions are:
- IDLE→RD_ACC when a read is accepted.
- IDLE→WR_SETUP when a write is accepted.
- RD_ACC→RD_TURN when the access count ends; the data bus is sampled on that edge.
- RD_TURN→IDLE when the turnaround count ends.
- WR_SETUP→WR_PULSE after one cycle.
- WR_PULSE→WR_END when the pulse count ends.
- WR_END→IDLE after one cycle.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever no transfer is in progress, chip select, write enable and output enable are high, the tristate enable is low and `req_ready` is high.
- R2: A transfer is taken only on a clock edge with `req_valid` and `req_ready` both high. `req_ready` stays low until the controller is back in standby. Request inputs that change while the controller is busy have no effect on the address or data driven.
- R3: A read holds chip select low, output enable low and write enable high for exactly RD_CYC cycles, with the requested address on the address lines throughout.
- R4: The byte on `sram_dq_in` at the edge that ends the read access appears on `rd_data`, with `rd_valid` high for exactly one cycle, in the cycle after the access ends.
- R5: After a read, all three strobes stay high for TA_CYC cycles before `req_ready` returns.
- R6: A write keeps chip select low and output enable high for WR_CYC+2 cycles. Write enable is high in the first cycle, low for exactly WR_CYC cycles, then high in the last cycle. The address does not change while write enable falls or is low.
- R7: The tristate enable is high through all WR_CYC+2 cycles of a write, with the request byte on `sram_dq_out`. It is never high while output enable is low, and it only rises after output enable was high in the previous cycle.
- R8: A write produces no `rd_valid` pulse.
- R9: Write enable is low only while chip select is low and output enable is high (a write never overlaps a read encoding).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse with read byte |
| rd_data | output | 8 | Captured read byte |
| sram_addr | output | 19 | RAM address lines |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Byte driven to the RAM |
| sram_dq_in | input | 8 | Byte read from the RAM pins |
| sram_dq_oe | output | 1 | Tristate enable for the data pins |

## Verification
A state register stuck in or skipping a phase shows at once as a strobe level that is wrong in the very next cycle. It also shows as `req_ready` returning early or late. An off-by-one in a phase counter lengthens or shortens the run of output enable or write enable lows by one cycle. A read sampled on the wrong edge returns a byte that differs from the one a behavioural RAM model presented. Since the bench checks every cycle of every transfer, each fault appears in the first transfer that uses the broken phase.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_END   = 3'd5
    } sc_state_t;

endpackage

// File: rtl/sram_ctrl_cnt.sv
module sram_ctrl_cnt #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2,
    parameter int TA_CYC = 1,
    parameter int CW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          cnt_done,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val,
    output logic          req_ready,
    output logic          accept,
    output logic          capture,
    output logic          cs_n,
    output logic          we_n,
    output logic          oe_n,
    output logic          dq_oe
);

    localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] TA_LOAD = CW'(TA_CYC - 1);

    sc_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state and phase control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACC;
                        cnt_load = 1'b1;
                        cnt_val  = RD_LOAD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (cnt_done) begin
                    capture  = 1'b1;
                    state_d  = ST_RD_TURN;
                    cnt_load = 1'b1;
                    cnt_val  = TA_LOAD;
                end
            end
            ST_RD_TURN: begin
                if (cnt_done) state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                cnt_load = 1'b1;
                cnt_val  = WR_LOAD;
            end
            ST_WR_PULSE: begin
                if (cnt_done) state_d = ST_WR_END;
            end
            ST_WR_END: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);

    // registered strobes, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            cs_n  <= !(state_d == ST_RD_ACC   || state_d == ST_WR_SETUP ||
                       state_d == ST_WR_PULSE || state_d == ST_WR_END);
            oe_n  <= (state_d != ST_RD_ACC);
            we_n  <= (state_d != ST_WR_PULSE);
            dq_oe <= (state_d == ST_WR_SETUP || state_d == ST_WR_PULSE ||
                      state_d == ST_WR_END);
        end
    end

    // R9
    wr_mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cs_n && oe_n));

    // R7
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    // R7
    drive_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> $past(oe_n));

    // R1
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && we_n && oe_n && !dq_oe));

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] dq_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            dq_out <= '0;
        end else if (accept) begin
            addr_o <= req_addr;
            dq_out <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= dq_in;
        end
    end

    // R4
    rd_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);

    localparam int MAX_A  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int MAX_C  = (MAX_A > TA_CYC) ? MAX_A : TA_CYC;
    localparam int CW     = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_done;
    logic          accept;
    logic          capture;

    sram_ctrl_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    sram_ctrl_fsm #(
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .TA_CYC (TA_CYC),
        .CW     (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .cnt_done  (cnt_done),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .cs_n      (sram_cs_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .dq_oe     (sram_dq_oe)
    );

    sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (sram_dq_in),
        .addr_o    (sram_addr),
        .dq_out    (sram_dq_out),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // R6
    addr_hold_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sram_we_n) || !sram_we_n) |-> $stable(sram_addr));

    // R8
    no_rd_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> !rd_valid);

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RD_CYC = 2;
    localparam int WR_CYC = 2;
    localparam int TA_CYC = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    byte unsigned ram_model[int];
    byte unsigned ref_mem[int];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctrl #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
    );

    // behavioural RAM: drives only in the read encoding, unwritten bytes read 0
    always @(sram_cs_n or sram_oe_n or sram_we_n or sram_addr) begin
        if (!sram_cs_n && !sram_oe_n && sram_we_n)
            sram_dq_in = ram_model.exists(int'(sram_addr)) ? ram_model[int'(sram_addr)] : 8'h00;
        else
            sram_dq_in = 8'h00;
    end

    always @(posedge sram_we_n) begin
        if (!sram_cs_n && sram_dq_oe) ram_model[int'(sram_addr)] = sram_dq_out;
    end

    function automatic logic [7:0] exp_read(logic [18:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    function automatic logic [18:0] pick_addr(int unsigned i);
        if (i == 0) return 19'h00000;
        if (i == 1) return 19'h7FFFF;
        return 19'((i * 32'h1357B) & 32'h7FFFF);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    task automatic chk_idle(string req);
        chk({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready} == 5'b11101,
            req, {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready}, 5'b11101);
    endtask

    // bus conflict monitor: R7
    always @(negedge clk) begin
        if (rst_n && !finished && sram_dq_oe && !sram_oe_n)
            chk(1'b0, "R7 drive while RAM enabled", 1, 0);
    end

    // called at a negedge where req_ready is high
    task automatic run_op(bit wr, logic [18:0] a, logic [7:0] d, bit noisy);
        logic [7:0] e;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) ref_mem[int'(a)] = d;
        e = exp_read(a);
        if (!wr) begin
            for (int k = 1; k <= RD_CYC + TA_CYC; k++) begin
                @(negedge clk);
                req_valid = noisy; req_addr = 19'($urandom); req_wdata = 8'($urandom);
                req_write = 1'($urandom);
                chk(!req_ready, "R2 ready low while busy", req_ready, 0);
                if (k <= RD_CYC) begin
                    chk({sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe} == 4'b0010,
                        "R3 read strobes", {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b0010);
                    chk(sram_addr == a, "R3 read address", sram_addr, a);
                end else begin
                    chk({sram_cs_n, sram_oe_n, sram_we_n} == 3'b111,
                        "R5 turnaround strobes", {sram_cs_n, sram_oe_n, sram_we_n}, 3'b111);
                end
                if (k == RD_CYC + 1) begin
                    chk(rd_valid, "R4 rd_valid pulse", rd_valid, 1);
                    chk(rd_data == e, "R4 read byte", rd_data, e);
                end else begin
                    chk(!rd_valid, "R4 rd_valid single cycle", rd_valid, 0);
                end
            end
        end else begin
            for (int k = 1; k <= WR_CYC + 2; k++) begin
                @(negedge clk);
                req_valid = noisy; req_addr = 19'($urandom); req_wdata = 8'($urandom);
                req_write = 1'($urandom);
                chk(!req_ready, "R2 ready low while busy", req_ready, 0);
                chk({sram_cs_n, sram_oe_n} == 2'b01, "R6 write cs/oe",
                    {sram_cs_n, sram_oe_n}, 2'b01);
                chk(sram_we_n == ((k == 1) || (k == WR_CYC + 2)), "R6 write enable shape",
                    sram_we_n, (k == 1) || (k == WR_CYC + 2));
                chk(sram_addr == a, "R6 write address", sram_addr, a);
                chk(sram_dq_oe && sram_dq_out == d, "R7 write data driven",
                    {sram_dq_oe, sram_dq_out}, {1'b1, d});
                chk(!rd_valid, "R8 no read pulse on write", rd_valid, 0);
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk_idle("R1 standby after transfer");
        chk(!rd_valid, "R4 rd_valid cleared", rd_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned s;
        s = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk_idle("R1 standby during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 standby after reset");
        chk(!rd_valid, "R1 no pulse after reset", rd_valid, 0);

        // directed corners: unwritten read, extreme addresses, write/read pairs
        run_op(1'b0, 19'h00123, 8'h00, 1'b0);
        run_op(1'b1, 19'h00000, 8'hA5, 1'b0);
        run_op(1'b1, 19'h7FFFF, 8'h5A, 1'b1);
        run_op(1'b0, 19'h00000, 8'h00, 1'b1);
        run_op(1'b0, 19'h7FFFF, 8'h00, 1'b0);
        run_op(1'b1, 19'h7FFFF, 8'hFF, 1'b0);
        run_op(1'b1, 19'h7FFFF, 8'h00, 1'b0);
        run_op(1'b0, 19'h7FFFF, 8'h00, 1'b0);

        // idle stretch with no request: R1
        repeat (3) begin
            @(negedge clk);
            chk_idle("R1 idle without request");
        end

        // constrained random mix over a small address pool
        for (int n = 0; n < 400; n++) begin
            run_op(1'($urandom), pick_addr($urandom % 10), 8'($urandom), 1'($urandom));
            if (($urandom % 4) == 0) begin
                @(negedge clk);
                chk_idle("R1 gap between transfers");
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule